// File: doc/BRIEF.md
# Programmable Chip-Select Decode Unit

This block decodes every bus cycle into one of ten active-low chip-select outputs. There is one upper-memory select, one lower-memory select and eight generic selects. Each select owns a window of the address space, set by a base register and a limit register. Both registers are written through a small register port. The decode is combinational from the bus inputs, so the selects and the wait-state count are valid in the same cycle as the address. Register writes take effect from the clock edge that accepts them.

A generic pin that is not enabled as a chip select becomes a general-purpose output. It then drives a bit from a port latch register, and the value on every generic pin can be read back on a dedicated output. When another master owns the bus, every chip select is forced inactive.

Top module: `cs_decode_unit`

## Requirements
- R1: After reset the upper select is enabled for memory cycles at byte addresses 0xFFC00 to 0xFFFFF, with a wait-state count of 15. The lower and generic selects are disabled, and the port latch reads all ones.
- R2: A window matches when the address bits [19:10] are at or above the base field and below the limit field. A limit field of 0 stands for the top of the address space (1024 blocks of 1 KB).
- R3: The limit register bit 2 chooses the cycle type for the upper and generic windows: 1 means I/O cycles (bus_io=1) only, and 0 means memory cycles only. The lower window answers memory cycles only and ignores bit 2.
- R4: A window whose enable bit (limit register bit 3) is 0 never asserts its select.
- R5: When windows overlap, the upper select wins first, then the lower select, then the generic selects in ascending index. At most one chip select is low at any time.
- R6: wait_states carries the base-register bits [3:0] of the winning window. It is 0 when no select is asserted.
- R7: A generic pin whose window is disabled drives bit g of the port latch register (register address 20, bits [7:0]).
- R8: port_rd reflects the value present on each generic pin.
- R9: With bus_valid low or hold_ack high, ucs_n, lcs_n and the enabled generic pins stay high and wait_states is 0. Pins in port mode keep their latch value.
- R10: Window w (0 = upper, 1 = lower, 2+g = generic g) has its base register at address 2w and its limit register at 2w+1. The base register holds the address field in bits [15:6]; the limit register holds the limit in bits [15:6]. Writes to addresses 21 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 16 | Register write data |
| bus_valid | input | 1 | A bus cycle is in progress |
| bus_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| bus_addr | input | 20 | Byte address of the cycle |
| hold_ack | input | 1 | Bus is granted to another master |
| ucs_n | output | 1 | Upper chip select, active low |
| lcs_n | output | 1 | Lower chip select, active low |
| gcs_n | output | 8 | Generic chip select or port output pins |
| wait_states | output | 4 | Wait-state count for the current cycle |
| port_rd | output | 8 | Readback of the generic pin values |

## Verification
The bench builds the block with its default parameters: a 20-bit address compared at 1 KB granularity, eight generic windows and 4-bit wait counts. With these values the whole address space is only 1024 blocks. Random windows therefore overlap often, the top-of-space limit code is easy to hit, and addresses chosen at block edges land exactly on every base and limit boundary. A behavioural model that works in byte addresses predicts all outputs, and the bench compares against it on every clock.

// File: rtl/cs_decode_pkg.sv
`timescale 1ns/1ps
package cs_decode_pkg;
  // limit register control bits
  localparam int LIM_EN_BIT = 3;
  localparam int LIM_IO_BIT = 2;
  // fixed window slots ahead of the generic ones
  localparam int SLOT_UPPER = 0;
  localparam int SLOT_LOWER = 1;
  localparam int SLOT_GEN0  = 2;
endpackage

// File: rtl/csd_regs.sv
`timescale 1ns/1ps
module csd_regs #(
  parameter int N_WIN  = 10,
  parameter int N_GEN  = 8,
  parameter int CMP_W  = 10,
  parameter int WS_W   = 4,
  parameter int REG_W  = 16,
  parameter int RA_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [RA_W-1:0]              reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic [N_WIN-1:0][CMP_W-1:0]  win_lo,
  output logic [N_WIN-1:0][CMP_W-1:0]  win_hi,
  output logic [N_WIN-1:0][WS_W-1:0]   win_ws,
  output logic [N_WIN-1:0]             win_en,
  output logic [N_WIN-1:0]             win_io,
  output logic [N_GEN-1:0]             port_latch
);
  import cs_decode_pkg::*;
  localparam int FIELD_LSB  = REG_W - CMP_W;
  localparam int LATCH_ADDR = 2 * N_WIN;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    localparam logic IS_UPPER = (w == SLOT_UPPER);
    logic base_sel, lim_sel;
    assign base_sel = reg_we && (reg_addr == RA_W'(2 * w));
    assign lim_sel  = reg_we && (reg_addr == RA_W'(2 * w + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_lo[w] <= IS_UPPER ? '1 : '0;
        win_ws[w] <= IS_UPPER ? '1 : '0;
        win_hi[w] <= '0;
        win_en[w] <= IS_UPPER;
        win_io[w] <= 1'b0;
      end else begin
        if (base_sel) begin
          win_lo[w] <= reg_wdata[REG_W-1:FIELD_LSB];
          win_ws[w] <= reg_wdata[WS_W-1:0];
        end
        if (lim_sel) begin
          win_hi[w] <= reg_wdata[REG_W-1:FIELD_LSB];
          win_en[w] <= reg_wdata[LIM_EN_BIT];
          win_io[w] <= reg_wdata[LIM_IO_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      port_latch <= '1;
    else if (reg_we && reg_addr == RA_W'(LATCH_ADDR))
      port_latch <= reg_wdata[N_GEN-1:0];
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(port_latch)); // R10
endmodule

// File: rtl/csd_window.sv
`timescale 1ns/1ps
module csd_window #(
  parameter int CMP_W    = 10,
  parameter bit MEM_ONLY = 1'b0
) (
  input  logic [CMP_W-1:0] addr_blk,
  input  logic             is_io,
  input  logic [CMP_W-1:0] lo,
  input  logic [CMP_W-1:0] hi,
  input  logic             en,
  input  logic             io_sel,
  output logic             hit
);
  // limit of zero means one past the last block
  function automatic logic in_range(input logic [CMP_W-1:0] a,
                                    input logic [CMP_W-1:0] b,
                                    input logic [CMP_W-1:0] l);
    logic [CMP_W:0] top;
    top = (l == '0) ? {1'b1, {CMP_W{1'b0}}} : {1'b0, l};
    return ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} < top);
  endfunction

  logic type_ok;
  if (MEM_ONLY) begin : g_mem
    assign type_ok = !is_io;
  end else begin : g_any
    assign type_ok = (io_sel == is_io);
  end

  assign hit = en && type_ok && in_range(addr_blk, lo, hi);
endmodule

// File: rtl/csd_arbiter.sv
`timescale 1ns/1ps
module csd_arbiter #(
  parameter int N_WIN = 10,
  parameter int WS_W  = 4
) (
  input  logic                       active,
  input  logic [N_WIN-1:0]           hit,
  input  logic [N_WIN-1:0][WS_W-1:0] ws,
  output logic [N_WIN-1:0]           grant,
  output logic [WS_W-1:0]            ws_out
);
  always_comb begin
    logic found;
    found  = 1'b0;
    grant  = '0;
    ws_out = '0;
    for (int w = 0; w < N_WIN; w++) begin
      if (active && hit[w] && !found) begin
        grant[w] = 1'b1;
        ws_out   = ws[w];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_decode_unit.sv
`timescale 1ns/1ps
module cs_decode_unit #(
  parameter int ADDR_W  = 20,
  parameter int CMP_LSB = 10,
  parameter int N_GEN   = 8,
  parameter int WS_W    = 4,
  parameter int REG_W   = 16,
  localparam int N_WIN  = N_GEN + 2,
  localparam int CMP_W  = ADDR_W - CMP_LSB,
  localparam int RA_W   = $clog2(2 * N_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              bus_valid,
  input  logic              bus_io,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              hold_ack,
  output logic              ucs_n,
  output logic              lcs_n,
  output logic [N_GEN-1:0]  gcs_n,
  output logic [WS_W-1:0]   wait_states,
  output logic [N_GEN-1:0]  port_rd
);
  import cs_decode_pkg::*;

  logic [N_WIN-1:0][CMP_W-1:0] win_lo, win_hi;
  logic [N_WIN-1:0][WS_W-1:0]  win_ws;
  logic [N_WIN-1:0]            win_en, win_io, win_hit, win_grant;
  logic [N_GEN-1:0]            port_latch, gen_en;
  logic [CMP_W-1:0]            addr_blk;
  logic                        cycle_active;

  assign addr_blk     = bus_addr[ADDR_W-1:CMP_LSB];
  assign cycle_active = bus_valid && !hold_ack;

  csd_regs #(.N_WIN(N_WIN), .N_GEN(N_GEN), .CMP_W(CMP_W), .WS_W(WS_W),
             .REG_W(REG_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .win_lo(win_lo), .win_hi(win_hi), .win_ws(win_ws),
    .win_en(win_en), .win_io(win_io), .port_latch(port_latch));

  for (genvar w = 0; w < N_WIN; w++) begin : g_cmp
    csd_window #(.CMP_W(CMP_W), .MEM_ONLY(w == SLOT_LOWER)) u_win (
      .addr_blk(addr_blk), .is_io(bus_io), .lo(win_lo[w]), .hi(win_hi[w]),
      .en(win_en[w]), .io_sel(win_io[w]), .hit(win_hit[w]));
  end

  csd_arbiter #(.N_WIN(N_WIN), .WS_W(WS_W)) u_arb (
    .active(cycle_active), .hit(win_hit), .ws(win_ws),
    .grant(win_grant), .ws_out(wait_states));

  assign ucs_n = !win_grant[SLOT_UPPER];
  assign lcs_n = !win_grant[SLOT_LOWER];

  for (genvar g = 0; g < N_GEN; g++) begin : g_pin
    assign gen_en[g] = win_en[SLOT_GEN0 + g];
    assign gcs_n[g]  = gen_en[g] ? !win_grant[SLOT_GEN0 + g] : port_latch[g];
  end

  assign port_rd = gcs_n;

  // chip selects seen at the pins
  logic [N_GEN+1:0] cs_low;
  assign cs_low = {~gcs_n & gen_en, !lcs_n, !ucs_n};

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_low) <= 1); // R5
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (cs_low == '0 && wait_states == '0)); // R9
  AST_LOWER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !lcs_n |-> !bus_io); // R3
  AST_WS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low == '0) |-> (wait_states == '0)); // R6
  AST_PORT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en == '0) |-> (gcs_n == port_latch)); // R7
endmodule

// File: tb/cs_decode_unit_bench.sv
`timescale 1ns/1ps
module cs_decode_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        bus_valid = 1'b0, bus_io = 1'b0, hold_ack = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        ucs_n, lcs_n;
  logic [7:0]  gcs_n, port_rd;
  logic [3:0]  wait_states;

  int errors = 0, checks = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  cs_decode_unit u_cs_decode_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bus_valid(bus_valid), .bus_io(bus_io),
    .bus_addr(bus_addr), .hold_ack(hold_ack), .ucs_n(ucs_n), .lcs_n(lcs_n),
    .gcs_n(gcs_n), .wait_states(wait_states), .port_rd(port_rd));

  // behavioural model state, in byte terms where it matters
  int m_base[10], m_lim[10], m_ws[10];
  bit m_en[10], m_io[10];
  bit [7:0] m_latch;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 10; w++) begin
        m_base[w] = (w == 0) ? 'hFFC00 : 0;
        m_lim[w]  = (w == 0) ? 'h100000 : 0;
        m_ws[w]   = (w == 0) ? 15 : 0;
        m_en[w]   = (w == 0);
        m_io[w]   = 0;
      end
      m_latch = 8'hFF;
    end else if (reg_we) begin
      if (reg_addr < 20) begin
        if (reg_addr % 2 == 0) begin
          m_base[reg_addr / 2] = int'(reg_wdata[15:6]) * 1024;
          m_ws[reg_addr / 2]   = int'(reg_wdata[3:0]);
        end else begin
          m_lim[reg_addr / 2] = (reg_wdata[15:6] == 0) ? 'h100000 : int'(reg_wdata[15:6]) * 1024;
          m_en[reg_addr / 2]  = reg_wdata[3];
          m_io[reg_addr / 2]  = reg_wdata[2];
        end
      end else if (reg_addr == 20) begin
        m_latch = reg_wdata[7:0];
      end
    end
  end

  task automatic compare();
    int win = -1;
    int a = int'(bus_addr);
    logic [21:0] exp_v, act_v;
    logic [7:0] pins;
    int ws_e = 0;
    if (bus_valid && !hold_ack)
      for (int w = 0; w < 10; w++) begin
        bit type_ok = (w == 1) ? !bus_io : (m_io[w] == bus_io);
        if (win < 0 && m_en[w] && type_ok && a >= m_base[w] && a < m_lim[w]) win = w;
      end
    if (win >= 0) ws_e = m_ws[win];
    for (int g = 0; g < 8; g++)
      pins[g] = m_en[g + 2] ? (win != g + 2) : m_latch[g];
    exp_v = {win != 0, win != 1, pins, ws_e[3:0], pins};
    act_v = {ucs_n, lcs_n, gcs_n, wait_states, port_rd};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h io=%0d: actual=%h expected=%h", cur_req, bus_addr, bus_io, act_v, exp_v);
    end
  endtask

  task automatic cyc(input bit v, input bit io, input int addr, input bit hold);
    @(posedge clk); #1;
    bus_valid = v; bus_io = io; bus_addr = addr[19:0]; hold_ack = hold;
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a[4:0]; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  function automatic logic [15:0] base_w(input int blk, input int ws);
    return {blk[9:0], 2'b00, ws[3:0]};
  endfunction
  function automatic logic [15:0] lim_w(input int blk, input bit en, input bit io);
    return {blk[9:0], 2'b00, en, io, 2'b00};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset window and port latch
    cur_req = "R1";
    cyc(1, 0, 'hFFBFF, 0); cyc(1, 0, 'hFFC00, 0); cyc(1, 0, 'hFFFFF, 0);
    cyc(1, 1, 'hFFC00, 0); cyc(1, 0, 'h00000, 0);
    // R10 and R2: generic 0 at blocks 1..2, boundaries
    cur_req = "R10";
    wr(4, base_w(1, 3)); wr(5, lim_w(2, 1, 0));
    cur_req = "R2";
    cyc(1, 0, 'h003FF, 0); cyc(1, 0, 'h00400, 0); cyc(1, 0, 'h007FF, 0); cyc(1, 0, 'h00800, 0);
    // R2: limit 0 reaches top of space
    wr(6, base_w(1020, 5)); wr(7, lim_w(0, 1, 0));
    cyc(1, 0, 'hFEFFF, 0); cyc(1, 0, 'hFF000, 0); cyc(1, 0, 'hFFFFF, 0);
    // R3: generic 1 as I/O, lower with I/O bit set still memory
    cur_req = "R3";
    wr(7, lim_w(0, 1, 1));
    cyc(1, 1, 'hFF800, 0); cyc(1, 0, 'hFF800, 0);
    wr(2, base_w(0, 2)); wr(3, lim_w(4, 1, 1));
    cyc(1, 0, 'h00C00, 0); cyc(1, 1, 'h00C00, 0); cyc(1, 0, 'h00100, 0);
    // R5: lower beats generic 0, generic 2 beats generic 3, upper beats generic 1
    cur_req = "R5";
    cyc(1, 0, 'h00500, 0);
    wr(8, base_w(16, 7)); wr(9, lim_w(32, 1, 0));
    wr(10, base_w(20, 9)); wr(11, lim_w(40, 1, 0));
    cyc(1, 0, 'h05000, 0); cyc(1, 0, 'h08000, 0); cyc(1, 0, 'h0A000, 0);
    wr(7, lim_w(0, 1, 0)); cyc(1, 0, 'hFFC10, 0);
    // R6: wait states of winner, zero on miss
    cur_req = "R6";
    cyc(1, 0, 'h80000, 0); cyc(1, 0, 'h06000, 0);
    // R4: disabled window silent
    cur_req = "R4";
    wr(9, lim_w(32, 0, 0)); cyc(1, 0, 'h05000, 0); cyc(1, 0, 'h04000, 0);
    wr(1, lim_w(0, 0, 0)); cyc(1, 0, 'hFFC00, 0);
    // R7 and R8: latch patterns on port-mode pins
    cur_req = "R7";
    wr(20, 16'h00A5); cyc(1, 0, 'h40000, 0);
    cur_req = "R8";
    wr(20, 16'h005A); cyc(0, 0, 'h00000, 0);
    // R9: hold and idle
    cur_req = "R9";
    cyc(1, 0, 'h00500, 1); cyc(0, 0, 'h00500, 0); cyc(1, 1, 'h00C00, 1);
    // R10: unmapped addresses ignored
    cur_req = "R10";
    for (int a = 21; a < 32; a++) wr(a, 16'h0000);
    cyc(1, 0, 'h00500, 0); cyc(1, 1, 'h00C00, 0); cyc(1, 0, 'h40000, 0);
    // R2: random windows and boundary-biased addresses
    cur_req = "R2";
    for (int i = 0; i < 1500; i++) begin
      int blk, off, sel;
      if ($urandom % 4 == 0) wr($urandom % 32, 16'($urandom));
      blk = $urandom % 1024;
      sel = $urandom % 3;
      off = (sel == 0) ? 0 : (sel == 1) ? 1023 : ($urandom % 1024);
      cyc(($urandom % 8) != 0, $urandom % 2, blk * 1024 + off, ($urandom % 8) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule